// File: doc/BRIEF.md
# UART Host Register Select

This block is the processor-facing front end of a 16550-class serial port. It qualifies three chip-select inputs against a fixed pattern. It holds the three-bit register offset and the chip selects either transparently or as captured on the rising edge of an address strobe. It then works out which internal register a read or a write refers to. The result depends on the offset, on the transfer direction and on the divisor-access bit, which the line control register owns and supplies on an input.

For each transfer the block raises one bit of a read-strobe or write-strobe vector for a single clock. While a read is in progress it returns the selected register's byte on the read-data output and raises a data-enable. It also pulls low a driver-disable line that an external bus transceiver can use to turn its direction around. The register contents live outside the block and arrive on a flat packed input, one byte per target.

Target indices, shared by both strobe vectors and the read-data input: 0 receive buffer, 1 transmit holding, 2 interrupt enable, 3 interrupt identification, 4 FIFO control, 5 line control, 6 modem control, 7 line status, 8 modem status, 9 scratch, 10 divisor low byte, 11 divisor high byte.

Top module: `uart_host_regsel`

## Requirements
- R1: The port counts as selected only when cs_i[0]=1, cs_i[1]=1 and cs_i[2]=0. Any other pattern produces no strobe, holds data_oe_o low, holds drv_dis_n_o high and holds rd_data_o at zero.
- R2: With div_access_i=0, offset 0 addresses target 0 on a read and target 1 on a write. Offset 1 addresses target 2 in both directions.
- R3: With div_access_i=1, offset 0 addresses target 10 and offset 1 addresses target 11, in both directions. Targets 10 and 11 are never strobed while div_access_i=0.
- R4: Offset 2 addresses target 3 on a read and target 4 on a write, whatever the value of div_access_i.
- R5: Offsets 3, 4, 5, 6 and 7 address targets 5, 6, 7, 8 and 9 in both directions, whatever the value of div_access_i.
- R6: A strobe bit is high only in the cycle in which rd_en_i (or wr_en_i) is high after having been low at the previous clock edge, with the port selected. Holding the enable high produces no further strobe. At most one bit of each strobe vector is high at a time.
- R7: When rd_en_i and wr_en_i are both high, neither strobe vector has any bit set, data_oe_o is low and rd_data_o is zero.
- R8: While addr_stb_i is low, offset and chip selects follow the inputs in the same cycle. A rising edge of addr_stb_i captures both. While addr_stb_i remains high after that edge, later changes on addr_i and cs_i have no effect.
- R9: While a read is active (rd_en_i high, wr_en_i low, port selected), rd_data_o equals byte k of reg_rdata_i (bits 8k+7..8k) for the addressed target k, data_oe_o is high and drv_dis_n_o is low. Otherwise rd_data_o is zero, data_oe_o is low and drv_dis_n_o is high.
- R10: After a synchronous active-low reset with both enables low, both strobe vectors are zero, data_oe_o is low, drv_dis_n_o is high and rd_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 3 | Register offset from the processor |
| cs_i | input | 3 | Chip-select inputs, matched against 0b011 |
| addr_stb_i | input | 1 | Address strobe; rising edge captures offset and chip selects, low means transparent |
| rd_en_i | input | 1 | Read enable |
| wr_en_i | input | 1 | Write enable |
| div_access_i | input | 1 | Divisor-access bit from the line control register |
| reg_rdata_i | input | 96 | Register contents, byte k for target k |
| rd_stb_o | output | 12 | One-cycle read strobe per target |
| wr_stb_o | output | 12 | One-cycle write strobe per target |
| rd_data_o | output | 8 | Read data, zero when no read is active |
| data_oe_o | output | 1 | High while the read data is valid to drive |
| drv_dis_n_o | output | 1 | Low while a read is in progress |

## Verification
The embedded properties assume that the address strobe is low while reset is asserted and that the enables rise only after reset has been released. Under those conditions the captured offset starts from a known state and the edge detectors do not see a phantom rising edge. The stimulus drives every input on the falling clock edge and keeps the strobe low through each reset. It only ever changes the offset and chip selects while the strobe is high after its rising edge has been seen at a clock, so the stability property is tested on exactly the case it describes.

// File: rtl/uart_hrs_pkg.sv
// Package: uart_hrs_pkg
// Shared widths, the register target enumeration and the offset map used by
// the host register select front end. Assumes an eight-register window
// addressed by a three-bit offset.
package uart_hrs_pkg;

    localparam int ADDR_W  = 3;
    localparam int CS_W    = 3;
    localparam int NUM_TGT = 12;
    localparam int TGT_W   = $clog2(NUM_TGT);

    typedef enum logic [TGT_W-1:0] {
        TGT_RXBUF    = 4'd0,
        TGT_TXHOLD   = 4'd1,
        TGT_INTEN    = 4'd2,
        TGT_INTID    = 4'd3,
        TGT_FIFOCTL  = 4'd4,
        TGT_LINECTL  = 4'd5,
        TGT_MDMCTL   = 4'd6,
        TGT_LINESTAT = 4'd7,
        TGT_MDMSTAT  = 4'd8,
        TGT_SCRATCH  = 4'd9,
        TGT_DIVLO    = 4'd10,
        TGT_DIVHI    = 4'd11
    } tgt_e;

    // Resolve an offset, a direction and the divisor-access bit to a target.
    function automatic tgt_e map_target(input logic [ADDR_W-1:0] off,
                                        input logic is_write,
                                        input logic div_acc);
        tgt_e t;
        case (off)
            3'd0: t = div_acc ? TGT_DIVLO : (is_write ? TGT_TXHOLD : TGT_RXBUF);
            3'd1: t = div_acc ? TGT_DIVHI : TGT_INTEN;
            3'd2: t = is_write ? TGT_FIFOCTL : TGT_INTID;
            3'd3: t = TGT_LINECTL;
            3'd4: t = TGT_MDMCTL;
            3'd5: t = TGT_LINESTAT;
            3'd6: t = TGT_MDMSTAT;
            default: t = TGT_SCRATCH;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/hrs_sel_latch.sv
// Module: hrs_sel_latch
// Holds the register offset and chip selects. While the strobe is low the
// inputs pass through in the same cycle. The cycle in which the strobe is
// seen high for the first time also passes the inputs through and captures
// them. After that, while the strobe stays high, the captured copy is used.
// Assumes the strobe is low while reset is asserted.
module hrs_sel_latch
    import uart_hrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CS_W-1:0]   cs_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CS_W-1:0]   cs_o
);

    logic              strobe_q;
    logic              strobe_rise;
    logic              use_held;
    logic [ADDR_W-1:0] addr_held;
    logic [CS_W-1:0]   cs_held;

    assign strobe_rise = strobe_i & ~strobe_q;
    assign use_held    = strobe_i & strobe_q;

    // Track the strobe and capture offset and selects on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q  <= 1'b0;
            addr_held <= '0;
            cs_held   <= '0;
        end else begin
            strobe_q <= strobe_i;
            if (strobe_rise) begin
                addr_held <= addr_i;
                cs_held   <= cs_i;
            end
        end
    end

    // Choose the captured copy or the live inputs.
    always_comb begin
        addr_o = use_held ? addr_held : addr_i;
        cs_o   = use_held ? cs_held   : cs_i;
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && strobe_i && $past(strobe_i)) |-> ($stable(addr_o) && $stable(cs_o))); // R8

endmodule

// File: rtl/hrs_cs_match.sv
// Module: hrs_cs_match
// Compares each chip-select input with its required level and reports a
// selection only when every input matches. Purely combinational.
module hrs_cs_match
    import uart_hrs_pkg::*;
#(
    parameter logic [CS_W-1:0] CS_MATCH = 3'b011
) (
    input  logic [CS_W-1:0] cs_i,
    output logic            sel_o
);

    logic [CS_W-1:0] bit_ok;

    // One comparator per select input, polarity fixed by CS_MATCH.
    for (genvar i = 0; i < CS_W; i++) begin : g_cs
        if (CS_MATCH[i]) begin : g_hi
            assign bit_ok[i] = cs_i[i];
        end else begin : g_lo
            assign bit_ok[i] = ~cs_i[i];
        end
    end

    assign sel_o = &bit_ok;

endmodule

// File: rtl/hrs_decode.sv
// Module: hrs_decode
// Turns the held offset, direction and divisor-access bit into one-hot read
// and write vectors. Level vectors drive the read mux, and pulse vectors fire
// on the cycle an enable rises. A cycle with both enables high is refused.
// Assumes both enables are low when reset is released.
module hrs_decode
    import uart_hrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              div_acc_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    output logic [NUM_TGT-1:0] rd_hot_o,
    output logic              rd_act_o,
    output logic [NUM_TGT-1:0] rd_stb_o,
    output logic [NUM_TGT-1:0] wr_stb_o
);

    logic               rd_en_q;
    logic               wr_en_q;
    logic               rd_act;
    logic               wr_act;
    logic               rd_rise;
    logic               wr_rise;
    tgt_e               rd_tgt;
    tgt_e               wr_tgt;
    logic [NUM_TGT-1:0] rd_hot;
    logic [NUM_TGT-1:0] wr_hot;

    // Remember last cycle's enables for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en_q <= 1'b0;
            wr_en_q <= 1'b0;
        end else begin
            rd_en_q <= rd_en_i;
            wr_en_q <= wr_en_i;
        end
    end

    // Qualify the transfer and resolve both candidate targets.
    always_comb begin
        rd_act  = rd_en_i & ~wr_en_i & sel_i;
        wr_act  = wr_en_i & ~rd_en_i & sel_i;
        rd_rise = rd_en_i & ~rd_en_q;
        wr_rise = wr_en_i & ~wr_en_q;
        rd_tgt  = map_target(addr_i, 1'b0, div_acc_i);
        wr_tgt  = map_target(addr_i, 1'b1, div_acc_i);
    end

    // One comparator per target for each direction.
    for (genvar k = 0; k < NUM_TGT; k++) begin : g_tgt
        assign rd_hot[k]   = rd_act && (int'(rd_tgt) == k);
        assign wr_hot[k]   = wr_act && (int'(wr_tgt) == k);
        assign rd_stb_o[k] = rd_hot[k] & rd_rise;
        assign wr_stb_o[k] = wr_hot[k] & wr_rise;
    end

    assign rd_hot_o = rd_hot;
    assign rd_act_o = rd_act;

    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_stb_o)); // R6
    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o)); // R6
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_stb_o) |=> (rd_stb_o == '0)); // R6
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb_o) |=> (wr_stb_o == '0)); // R6
    AST_NO_RW_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && wr_en_i) |-> ((rd_stb_o == '0) && (wr_stb_o == '0))); // R7
    AST_DIV_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_o[TGT_DIVLO] || rd_stb_o[TGT_DIVHI] ||
         wr_stb_o[TGT_DIVLO] || wr_stb_o[TGT_DIVHI]) |-> div_acc_i); // R3

endmodule

// File: rtl/hrs_rdmux.sv
// Module: hrs_rdmux
// Selects one register byte by the one-hot read vector with an AND-OR
// structure. Drives zero, output-enable low and driver-disable high when no
// read is active. Purely combinational.
module hrs_rdmux
    import uart_hrs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NUM_TGT-1:0]        rd_hot_i,
    input  logic                      rd_act_i,
    input  logic [NUM_TGT*DATA_W-1:0] reg_rdata_i,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      data_oe_o,
    output logic                      drv_dis_n_o
);

    logic [DATA_W-1:0] masked [NUM_TGT];

    // Gate each register byte by its select bit.
    for (genvar k = 0; k < NUM_TGT; k++) begin : g_mask
        assign masked[k] = rd_hot_i[k] ? reg_rdata_i[k*DATA_W +: DATA_W] : '0;
    end

    // OR the gated bytes together into the bus value.
    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_TGT; k++) begin
            rd_data_o = rd_data_o | masked[k];
        end
        data_oe_o   = rd_act_i;
        drv_dis_n_o = ~rd_act_i;
    end

endmodule

// File: rtl/uart_host_regsel.sv
// Module: uart_host_regsel
// Host-side register select front end of a UART: chip-select qualification,
// strobe-captured or transparent addressing, direction- and divisor-aware
// decode, one-cycle register strobes and the read-data mux. Register
// contents are external. Assumes a synchronous active-low reset with the
// address strobe and both enables low while it is asserted.
module uart_host_regsel
    import uart_hrs_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter logic [CS_W-1:0] CS_MATCH = 3'b011
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [CS_W-1:0]           cs_i,
    input  logic                      addr_stb_i,
    input  logic                      rd_en_i,
    input  logic                      wr_en_i,
    input  logic                      div_access_i,
    input  logic [NUM_TGT*DATA_W-1:0] reg_rdata_i,
    output logic [NUM_TGT-1:0]        rd_stb_o,
    output logic [NUM_TGT-1:0]        wr_stb_o,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      data_oe_o,
    output logic                      drv_dis_n_o
);

    logic [ADDR_W-1:0]  addr_eff;
    logic [CS_W-1:0]    cs_eff;
    logic               chip_sel;
    logic [NUM_TGT-1:0] rd_hot;
    logic               rd_act;

    hrs_sel_latch i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (addr_stb_i),
        .addr_i   (addr_i),
        .cs_i     (cs_i),
        .addr_o   (addr_eff),
        .cs_o     (cs_eff)
    );

    hrs_cs_match #(.CS_MATCH(CS_MATCH)) i_cs (
        .cs_i  (cs_eff),
        .sel_o (chip_sel)
    );

    hrs_decode i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (chip_sel),
        .addr_i    (addr_eff),
        .div_acc_i (div_access_i),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .rd_hot_o  (rd_hot),
        .rd_act_o  (rd_act),
        .rd_stb_o  (rd_stb_o),
        .wr_stb_o  (wr_stb_o)
    );

    hrs_rdmux #(.DATA_W(DATA_W)) i_mux (
        .rd_hot_i    (rd_hot),
        .rd_act_i    (rd_act),
        .reg_rdata_i (reg_rdata_i),
        .rd_data_o   (rd_data_o),
        .data_oe_o   (data_oe_o),
        .drv_dis_n_o (drv_dis_n_o)
    );

    AST_STB_HAS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_stb_o) |-> (data_oe_o && !drv_dis_n_o)); // R9
    AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb_o) |-> (!data_oe_o && rd_data_o == '0)); // R9

endmodule

// File: tb/test_uart_host_regsel.sv
module test_uart_host_regsel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [2:0]  cs = '0;
    logic        astb = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        dacc = 1'b0;
    logic [95:0] rdata;
    logic [11:0] rd_stb;
    logic [11:0] wr_stb;
    logic [7:0]  rd_data;
    logic        oe;
    logic        ddis_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] salt = 8'h00;

    always #2 clk = ~clk;

    uart_host_regsel i_uart_host_regsel (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr),
        .cs_i         (cs),
        .addr_stb_i   (astb),
        .rd_en_i      (rd_en),
        .wr_en_i      (wr_en),
        .div_access_i (dacc),
        .reg_rdata_i  (rdata),
        .rd_stb_o     (rd_stb),
        .wr_stb_o     (wr_stb),
        .rd_data_o    (rd_data),
        .data_oe_o    (oe),
        .drv_dis_n_o  (ddis_n)
    );

    function automatic logic [7:0] byte_of(int k, logic [7:0] s);
        return (8'h30 + 8'(k * 7)) ^ s;
    endfunction

    always_comb begin
        for (int k = 0; k < 12; k++) rdata[k*8 +: 8] = byte_of(k, salt);
    end

    // Expected target from the requirements' offset map.
    function automatic int exp_tgt(logic [2:0] off, bit is_wr, bit d);
        case (off)
            3'd0: return d ? 10 : (is_wr ? 1 : 0);
            3'd1: return d ? 11 : 2;
            3'd2: return is_wr ? 4 : 3;
            default: return int'(off) + 2;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_outputs(input string req);
        check(req, 32'(rd_stb), 0);
        check(req, 32'(wr_stb), 0);
        check(req, 32'(oe), 0);
        check(req, 32'(ddis_n), 1);
        check(req, 32'(rd_data), 0);
    endtask

    // One selected transfer; checks strobe, data and the clearing of the strobe.
    task automatic access(input bit is_wr, input logic [2:0] off, input bit d, input string req);
        int t;
        @(negedge clk);
        addr = off; dacc = d; cs = 3'b011;
        rd_en = !is_wr; wr_en = is_wr;
        #1;
        t = exp_tgt(off, is_wr, d);
        if (is_wr) begin
            check(req, 32'(wr_stb), 32'(12'(1) << t));
            check(req, 32'(rd_stb), 0);
            check(req, 32'(oe), 0);
        end else begin
            check(req, 32'(rd_stb), 32'(12'(1) << t));
            check(req, 32'(wr_stb), 0);
            check(req, 32'(rd_data), 32'(byte_of(t, salt)));
            check(req, 32'(oe), 1);
            check(req, 32'(ddis_n), 0);
        end
        @(posedge clk); #1;
        check(req, 32'(rd_stb | wr_stb), 0);
        @(negedge clk);
        rd_en = 0; wr_en = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        idle_outputs("R10");
    endtask

    task automatic t_chip_select();
        logic [2:0] bad [4] = '{3'b111, 3'b001, 3'b010, 3'b000};
        foreach (bad[i]) begin
            @(negedge clk);
            cs = bad[i]; addr = 3'd3; dacc = 0; rd_en = 1;
            #1;
            idle_outputs("R1");
            @(negedge clk); rd_en = 0;
        end
        access(0, 3'd3, 0, "R1");
    endtask

    task automatic t_dlab0();
        access(0, 3'd0, 0, "R2");
        access(1, 3'd0, 0, "R2");
        access(0, 3'd1, 0, "R2");
        access(1, 3'd1, 0, "R2");
    endtask

    task automatic t_dlab1();
        access(0, 3'd0, 1, "R3");
        access(1, 3'd0, 1, "R3");
        access(0, 3'd1, 1, "R3");
        access(1, 3'd1, 1, "R3");
    endtask

    task automatic t_shared();
        for (int d = 0; d < 2; d++) begin
            access(0, 3'd2, d[0], "R4");
            access(1, 3'd2, d[0], "R4");
            for (int o = 3; o < 8; o++) begin
                access(0, 3'(o), d[0], "R5");
                access(1, 3'(o), d[0], "R5");
            end
        end
    endtask

    task automatic t_hold();
        @(negedge clk);
        cs = 3'b011; addr = 3'd7; dacc = 0; rd_en = 1;
        #1;
        check("R6", 32'(rd_stb), 32'(12'(1) << 9));
        repeat (3) begin
            @(posedge clk); #1;
            check("R6", 32'(rd_stb), 0);
            check("R9", 32'(oe), 1);
            check("R9", 32'(rd_data), 32'(byte_of(9, salt)));
        end
        @(negedge clk); rd_en = 0;
        #1;
        idle_outputs("R9");
        @(negedge clk); wr_en = 1; addr = 3'd4;
        #1;
        check("R6", 32'(wr_stb), 32'(12'(1) << 6));
        @(posedge clk); #1;
        check("R6", 32'(wr_stb), 0);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic t_both();
        @(negedge clk);
        cs = 3'b011; addr = 3'd5; rd_en = 1; wr_en = 1;
        #1;
        idle_outputs("R7");
        @(negedge clk); rd_en = 0; wr_en = 0;
    endtask

    task automatic t_strobe();
        @(negedge clk);
        cs = 3'b011; addr = 3'd5; dacc = 0; astb = 1;
        @(negedge clk);
        addr = 3'd0; cs = 3'b000; rd_en = 1;
        #1;
        check("R8", 32'(rd_stb), 32'(12'(1) << 7));
        check("R8", 32'(rd_data), 32'(byte_of(7, salt)));
        @(negedge clk); rd_en = 0;
        @(negedge clk); astb = 0; rd_en = 1;
        #1;
        idle_outputs("R8");
        @(negedge clk); rd_en = 0; cs = 3'b011;
        @(negedge clk); rd_en = 1;
        #1;
        check("R8", 32'(rd_stb), 32'(12'(1) << 0));
        @(negedge clk); rd_en = 0;
    endtask

    initial begin
        t_reset();
        t_chip_select();
        t_dlab0();
        t_dlab1();
        salt = 8'h5A;
        t_shared();
        t_hold();
        t_both();
        salt = 8'hC3;
        t_strobe();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule